// File: doc/BRIEF.md
# Two-Stage Keyed Watchdog Timer

This block is a watchdog peripheral on a simple register bus: address, write data, write strobe, byte enables and a combinational read port. Once enabled, a prescaled tick drives one countdown through two stages. When the first stage runs out, the block can pulse one of three interrupt lines. The second stage then counts its own preload. When that stage runs out, the block raises a one-cycle reset pulse and latches a sticky timeout flag. Software keeps the system alive by restarting the countdown before the second stage expires.

The preload registers and the reload/status register are guarded. Software must first write two key words to the reload address. That arming admits exactly one protected write, and the key must be repeated for every further protected write. A lock bit makes the enable bit impossible to clear until the block's own reset input. A function bit turns the block into a periodic timer that never resets the system.

Top module: `kwdt_top`

## Requirements
- R1: Registers sit at byte offsets 0x00 (control), 0x04 (config), 0x08 (preload A), 0x0C (preload B) and 0x10 (reload/status). Protected writes are armed only by writing 0x0080 and then 0x0086 to offset 0x10, with byte enables 0 and 1 both set. Any other write to 0x10 between the two words, including a key word with a missing byte enable, cancels the sequence.
- R2: One arming admits exactly one write to a preload or to the reload register. An unarmed protected write is silently dropped. Reads never consume an arming.
- R3: Each preload register holds 20 bits. Bits above 19 are dropped on write and read as zero. Each byte lane is written only when its byte enable is set.
- R4: An accepted write of 1 to reload bit 8 restarts stage A from preload A. A stage loaded with P expires on the (P+1)th tick after loading. Stage A expiry loads stage B from preload B.
- R5: A tick occurs every 2^SLOW_SHIFT clocks when config bit 2 is 0, and every 2^FAST_SHIFT clocks when it is 1. The prescaler restarts on every reload.
- R6: Stage A expiry produces a registered one-cycle pulse on irq_out[config bits 1:0]. The code 11 produces no interrupt. At most one line is ever high.
- R7: In watchdog function (control bit 2 = 0), stage B expiry sets reload bit 9 and pulses wdt_rst_out for one cycle, unless config bit 5 is 1, which suppresses only the pulse. Counting then resumes at stage A.
- R8: Reload bit 9 stays set until an accepted write with bit 9 at 1 clears it. A set event in the same cycle as a clear wins.
- R9: With control bit 2 = 1 (timer function), stage B expiry neither sets the flag nor pulses the reset.
- R10: While control bit 1 (enable) is 0, the countdown is held at preload A and no interrupt or reset pulse occurs.
- R11: Control bit 0 (lock) is sticky. While it is set, the enable bit cannot be cleared. Only the rst input clears lock, enable and the flag; the block's own reset pulse does not.
- R12: If a reload lands on the same edge as a stage expiry, the reload wins and the expiry is discarded.
- R13: After rst, control reads 0, config reads 0x03, both preloads read PRE_RST and the reload register reads 0. Unused config bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_be | input | 4 | Byte enables for the write |
| bus_rdata | output | 32 | Read data for bus_addr |
| irq_out | output | 3 | Stage A interrupt pulses, one line per type |
| wdt_rst_out | output | 1 | One-cycle system reset request |

## Verification
A restart command and a stage expiry can land on the same clock edge. The bench provokes this with preload A set to 1 and the fast tick. It issues a restart, idles one cycle, then sends the key and a second restart, so that the second restart lands exactly on the edge where stage A would expire. A correct design shows no interrupt on that edge and its first interrupt four cycles after the second restart. A design that lets the expiry win shows an interrupt at once. Flag set and flag clear can also coincide; a checker property covers that case and requires the set to win.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;

    localparam int ADDR_W = 5;
    localparam int DATA_W = 32;
    localparam int BE_W   = DATA_W / 8;
    localparam int IRQ_N  = 3;

    localparam logic [ADDR_W-1:0] OFS_CTL   = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_CFG   = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_PRE_A = 5'h08;
    localparam logic [ADDR_W-1:0] OFS_PRE_B = 5'h0C;
    localparam logic [ADDR_W-1:0] OFS_RLD   = 5'h10;

    localparam logic [15:0] KEY_FIRST  = 16'h0080;
    localparam logic [15:0] KEY_SECOND = 16'h0086;

    localparam int RLD_CMD_BIT  = 8;
    localparam int RLD_FLAG_BIT = 9;

    typedef enum logic [1:0] {
        KEY_IDLE  = 2'd0,
        KEY_HALF  = 2'd1,
        KEY_ARMED = 2'd2
    } key_st_e;

    typedef enum logic {
        STG_A = 1'b0,
        STG_B = 1'b1
    } stage_e;

    typedef struct packed {
        logic       rst_off;
        logic       fast;
        logic [1:0] itype;
    } cfg_t;

    typedef struct packed {
        logic func;
        logic en;
        logic lock;
    } ctl_t;

    function automatic logic [DATA_W-1:0] lane_merge(
        input logic [DATA_W-1:0] old_v,
        input logic [DATA_W-1:0] new_v,
        input logic [BE_W-1:0]   be
    );
        logic [DATA_W-1:0] r;
        r = old_v;
        for (int b = 0; b < BE_W; b++) begin
            if (be[b]) r[8*b +: 8] = new_v[8*b +: 8];
        end
        return r;
    endfunction

    function automatic logic key_word(
        input logic [15:0] w,
        input logic [1:0]  be,
        input logic [15:0] k
    );
        return (be == 2'b11) && (w == k);
    endfunction

endpackage

// File: rtl/kwdt_keygate.sv
module kwdt_keygate
    import kwdt_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_rld,
    input  logic        wr_pre,
    input  logic [15:0] wlo,
    input  logic [1:0]  be_lo,
    output logic        accept,
    output key_st_e     state
);

    key_st_e nxt;

    always_comb begin
        nxt    = state;
        accept = 1'b0;
        unique case (state)
            KEY_IDLE: begin
                if (wr_rld && key_word(wlo, be_lo, KEY_FIRST)) nxt = KEY_HALF;
            end
            KEY_HALF: begin
                if (wr_rld) begin
                    nxt = key_word(wlo, be_lo, KEY_SECOND) ? KEY_ARMED : KEY_IDLE;
                end
            end
            KEY_ARMED: begin
                if (wr_rld || wr_pre) begin
                    accept = 1'b1;
                    nxt    = KEY_IDLE;
                end
            end
            default: nxt = KEY_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= KEY_IDLE;
        else     state <= nxt;
    end

endmodule

// File: rtl/kwdt_regs.sv
module kwdt_regs
    import kwdt_pkg::*;
#(
    parameter int              PRE_W   = 20,
    parameter logic [PRE_W-1:0] PRE_RST = 20'd15360
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              we,
    input  logic [BE_W-1:0]   be,
    input  logic              flag_set,
    output logic [DATA_W-1:0] rdata,
    output cfg_t              cfg_q,
    output ctl_t              ctl_q,
    output logic [PRE_W-1:0]  pre_a,
    output logic [PRE_W-1:0]  pre_b,
    output logic              reload_cmd,
    output logic              flag_clr,
    output logic              flag_q,
    output key_st_e           key_st
);

    logic wr_rld, wr_pre_a, wr_pre_b, accept;
    logic [DATA_W-1:0] merge_a, merge_b;

    assign wr_rld   = we && (addr == OFS_RLD);
    assign wr_pre_a = we && (addr == OFS_PRE_A);
    assign wr_pre_b = we && (addr == OFS_PRE_B);

    kwdt_keygate u_key (
        .clk    (clk),
        .rst    (rst),
        .wr_rld (wr_rld),
        .wr_pre (wr_pre_a || wr_pre_b),
        .wlo    (wdata[15:0]),
        .be_lo  (be[1:0]),
        .accept (accept),
        .state  (key_st)
    );

    assign reload_cmd = accept && wr_rld && be[1] && wdata[RLD_CMD_BIT];
    assign flag_clr   = accept && wr_rld && be[1] && wdata[RLD_FLAG_BIT];

    assign merge_a = lane_merge(DATA_W'(pre_a), wdata, be);
    assign merge_b = lane_merge(DATA_W'(pre_b), wdata, be);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q  <= '0;
            cfg_q  <= '{rst_off: 1'b0, fast: 1'b0, itype: 2'b11};
            pre_a  <= PRE_RST;
            pre_b  <= PRE_RST;
            flag_q <= 1'b0;
        end else begin
            if (we && (addr == OFS_CTL) && be[0]) begin
                ctl_q.lock <= ctl_q.lock | wdata[0];
                ctl_q.en   <= ctl_q.lock ? (ctl_q.en | wdata[1]) : wdata[1];
                ctl_q.func <= wdata[2];
            end
            if (we && (addr == OFS_CFG) && be[0]) begin
                cfg_q.rst_off <= wdata[5];
                cfg_q.fast    <= wdata[2];
                cfg_q.itype   <= wdata[1:0];
            end
            if (accept && wr_pre_a) pre_a <= merge_a[PRE_W-1:0];
            if (accept && wr_pre_b) pre_b <= merge_b[PRE_W-1:0];
            if (flag_set)      flag_q <= 1'b1;
            else if (flag_clr) flag_q <= 1'b0;
        end
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            OFS_CTL:   rdata = DATA_W'({ctl_q.func, ctl_q.en, ctl_q.lock});
            OFS_CFG:   rdata = DATA_W'({cfg_q.rst_off, 2'b00, cfg_q.fast, cfg_q.itype});
            OFS_PRE_A: rdata = DATA_W'(pre_a);
            OFS_PRE_B: rdata = DATA_W'(pre_b);
            OFS_RLD:   rdata[RLD_FLAG_BIT] = flag_q;
            default:   rdata = '0;
        endcase
    end

endmodule

// File: rtl/kwdt_prescale.sv
module kwdt_prescale #(
    parameter int SLOW_SHIFT = 15,
    parameter int FAST_SHIFT = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic clear,
    input  logic fast,
    output logic tick
);

    localparam int DIV_W = (SLOW_SHIFT > FAST_SHIFT) ? SLOW_SHIFT : FAST_SHIFT;
    localparam logic [DIV_W-1:0] LIM_SLOW = DIV_W'((64'd1 << SLOW_SHIFT) - 64'd1);
    localparam logic [DIV_W-1:0] LIM_FAST = DIV_W'((64'd1 << FAST_SHIFT) - 64'd1);

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] limit;

    assign limit = fast ? LIM_FAST : LIM_SLOW;
    assign tick  = run && !clear && (div_q >= limit);

    always_ff @(posedge clk) begin
        if (rst || clear || !run) div_q <= '0;
        else if (tick)            div_q <= '0;
        else                      div_q <= div_q + 1'b1;
    end

endmodule

// File: rtl/kwdt_count.sv
module kwdt_count
    import kwdt_pkg::*;
#(
    parameter int PRE_W = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             en,
    input  logic             reload_cmd,
    input  logic             func,
    input  logic             rst_off,
    input  logic [1:0]       itype,
    input  logic [PRE_W-1:0] pre_a,
    input  logic [PRE_W-1:0] pre_b,
    output logic [IRQ_N-1:0] irq_q,
    output logic             rst_pulse_q,
    output logic             exp2_wd
);

    logic [PRE_W-1:0] count_q;
    stage_e           stage_q;
    logic             expire, exp1, exp2;

    assign expire  = en && !reload_cmd && tick && (count_q == '0);
    assign exp1    = expire && (stage_q == STG_A);
    assign exp2    = expire && (stage_q == STG_B);
    assign exp2_wd = exp2 && !func;

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
            stage_q <= STG_A;
        end else if (!en || reload_cmd) begin
            count_q <= pre_a;
            stage_q <= STG_A;
        end else if (tick) begin
            if (count_q == '0) begin
                if (stage_q == STG_A) begin
                    stage_q <= STG_B;
                    count_q <= pre_b;
                end else begin
                    stage_q <= STG_A;
                    count_q <= pre_a;
                end
            end else begin
                count_q <= count_q - 1'b1;
            end
        end
    end

    for (genvar i = 0; i < IRQ_N; i++) begin : g_irq
        always_ff @(posedge clk) begin
            if (rst) irq_q[i] <= 1'b0;
            else     irq_q[i] <= exp1 && (itype == 2'(i));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rst_pulse_q <= 1'b0;
        else     rst_pulse_q <= exp2_wd && !rst_off;
    end

endmodule

// File: rtl/kwdt_top.sv
module kwdt_top
    import kwdt_pkg::*;
#(
    parameter int              PRE_W      = 20,
    parameter logic [PRE_W-1:0] PRE_RST    = 20'd15360,
    parameter int              SLOW_SHIFT = 15,
    parameter int              FAST_SHIFT = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    input  logic [BE_W-1:0]   bus_be,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [IRQ_N-1:0]  irq_out,
    output logic              wdt_rst_out
);

    cfg_t             cfg_q;
    ctl_t             ctl_q;
    logic [PRE_W-1:0] pre_a, pre_b;
    logic             reload_cmd, flag_clr, flag_q, exp2_wd, tick;
    key_st_e          key_st;
    logic             lock_s, en_s, func_s, key_armed, prot_wr;

    assign lock_s    = ctl_q.lock;
    assign en_s      = ctl_q.en;
    assign func_s    = ctl_q.func;
    assign key_armed = (key_st == KEY_ARMED);
    assign prot_wr   = bus_we && ((bus_addr == OFS_RLD) || (bus_addr == OFS_PRE_A) ||
                                  (bus_addr == OFS_PRE_B));

    kwdt_regs #(.PRE_W(PRE_W), .PRE_RST(PRE_RST)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .addr       (bus_addr),
        .wdata      (bus_wdata),
        .we         (bus_we),
        .be         (bus_be),
        .flag_set   (exp2_wd),
        .rdata      (bus_rdata),
        .cfg_q      (cfg_q),
        .ctl_q      (ctl_q),
        .pre_a      (pre_a),
        .pre_b      (pre_b),
        .reload_cmd (reload_cmd),
        .flag_clr   (flag_clr),
        .flag_q     (flag_q),
        .key_st     (key_st)
    );

    kwdt_prescale #(.SLOW_SHIFT(SLOW_SHIFT), .FAST_SHIFT(FAST_SHIFT)) u_pre (
        .clk   (clk),
        .rst   (rst),
        .run   (ctl_q.en),
        .clear (reload_cmd),
        .fast  (cfg_q.fast),
        .tick  (tick)
    );

    kwdt_count #(.PRE_W(PRE_W)) u_cnt (
        .clk         (clk),
        .rst         (rst),
        .tick        (tick),
        .en          (ctl_q.en),
        .reload_cmd  (reload_cmd),
        .func        (ctl_q.func),
        .rst_off     (cfg_q.rst_off),
        .itype       (cfg_q.itype),
        .pre_a       (pre_a),
        .pre_b       (pre_b),
        .irq_q       (irq_out),
        .rst_pulse_q (wdt_rst_out),
        .exp2_wd     (exp2_wd)
    );

endmodule

// File: rtl/kwdt_checker.sv
module kwdt_checker
    import kwdt_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             lock_s,
    input logic             en_s,
    input logic             func_s,
    input logic             flag_q,
    input logic             flag_clr,
    input logic             exp2_wd,
    input logic             key_armed,
    input logic             prot_wr,
    input logic [IRQ_N-1:0] irq_out,
    input logic             wdt_rst_out
);

    assert_key_single_use_R2: assert property (@(posedge clk) disable iff (rst)
        (key_armed && prot_wr) |=> !key_armed);

    assert_irq_onehot_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(irq_out));

    assert_rst_one_cycle_R7: assert property (@(posedge clk) disable iff (rst)
        wdt_rst_out |=> !wdt_rst_out);

    assert_rst_sets_flag_R7: assert property (@(posedge clk) disable iff (rst)
        wdt_rst_out |-> flag_q);

    assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !flag_clr) |=> flag_q);

    assert_set_beats_clear_R8: assert property (@(posedge clk) disable iff (rst)
        (exp2_wd && flag_clr) |=> flag_q);

    assert_timer_no_reset_R9: assert property (@(posedge clk) disable iff (rst)
        func_s |=> !wdt_rst_out);

    assert_disabled_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        !en_s |=> ((irq_out == '0) && !wdt_rst_out));

    assert_lock_sticky_R11: assert property (@(posedge clk) disable iff (rst)
        lock_s |=> lock_s);

    assert_lock_holds_en_R11: assert property (@(posedge clk) disable iff (rst)
        (lock_s && en_s) |=> en_s);

endmodule

bind kwdt_top kwdt_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .lock_s      (lock_s),
    .en_s        (en_s),
    .func_s      (func_s),
    .flag_q      (flag_q),
    .flag_clr    (flag_clr),
    .exp2_wd     (exp2_wd),
    .key_armed   (key_armed),
    .prot_wr     (prot_wr),
    .irq_out     (irq_out),
    .wdt_rst_out (wdt_rst_out)
);

// File: tb/tb_kwdt_top.sv
module tb_kwdt_top;

    localparam int CLK_PERIOD = 10;
    localparam logic [19:0] PRE_RST = 20'h03C00;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_be = 4'hF;
    logic [31:0] bus_rdata;
    logic [2:0]  irq_out;
    logic        wdt_rst_out;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    kwdt_top #(.PRE_RST(PRE_RST), .SLOW_SHIFT(3), .FAST_SHIFT(1)) dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_be(bus_be), .bus_rdata(bus_rdata),
        .irq_out(irq_out), .wdt_rst_out(wdt_rst_out)
    );

    localparam logic [4:0] A_CTL = 5'h00, A_CFG = 5'h04, A_PA = 5'h08,
                           A_PB = 5'h0C, A_RLD = 5'h10;

    typedef struct packed {
        logic [23:0] tag;
        logic        wr;
        logic [4:0]  addr;
        logic [3:0]  be;
        logic [31:0] data;
    } vec_t;

    localparam int NV = 30;
    localparam vec_t VEC [NV] = '{
        '{"R13", 1'b0, A_PA,  4'hF, 32'h0000_3C00},
        '{"R2",  1'b1, A_PA,  4'hF, 32'h0001_2345},
        '{"R2",  1'b0, A_PA,  4'hF, 32'h0000_3C00},
        '{"R1",  1'b1, A_RLD, 4'hF, 32'h0000_0080},
        '{"R1",  1'b1, A_RLD, 4'hF, 32'h0000_0086},
        '{"R3",  1'b1, A_PA,  4'hF, 32'hFFF1_2345},
        '{"R3",  1'b0, A_PA,  4'hF, 32'h0001_2345},
        '{"R2",  1'b1, A_PA,  4'hF, 32'h0000_0005},
        '{"R2",  1'b0, A_PA,  4'hF, 32'h0001_2345},
        '{"R1",  1'b1, A_RLD, 4'hF, 32'h0000_0080},
        '{"R1",  1'b1, A_RLD, 4'hF, 32'h0000_0001},
        '{"R1",  1'b1, A_RLD, 4'hF, 32'h0000_0086},
        '{"R1",  1'b1, A_PB,  4'hF, 32'h0000_0007},
        '{"R1",  1'b0, A_PB,  4'hF, 32'h0000_3C00},
        '{"R2",  1'b1, A_RLD, 4'hF, 32'h0000_0080},
        '{"R2",  1'b1, A_RLD, 4'hF, 32'h0000_0086},
        '{"R13", 1'b0, A_RLD, 4'hF, 32'h0000_0000},
        '{"R2",  1'b1, A_PB,  4'hF, 32'h0000_0002},
        '{"R2",  1'b0, A_PB,  4'hF, 32'h0000_0002},
        '{"R3",  1'b1, A_RLD, 4'hF, 32'h0000_0080},
        '{"R3",  1'b1, A_RLD, 4'hF, 32'h0000_0086},
        '{"R3",  1'b1, A_PA,  4'h1, 32'hAAAA_AA77},
        '{"R3",  1'b0, A_PA,  4'hF, 32'h0001_2377},
        '{"R1",  1'b1, A_RLD, 4'hF, 32'h0000_0080},
        '{"R1",  1'b1, A_RLD, 4'h1, 32'h0000_0086},
        '{"R1",  1'b1, A_PB,  4'hF, 32'h0000_0009},
        '{"R1",  1'b0, A_PB,  4'hF, 32'h0000_0002},
        '{"R13", 1'b1, A_CFG, 4'hF, 32'h0000_0024},
        '{"R13", 1'b0, A_CFG, 4'hF, 32'h0000_0024},
        '{"R13", 1'b1, A_CFG, 4'hF, 32'hFFFF_FFDB}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [4:0] a, input logic [31:0] d, input logic [3:0] b);
        bus_addr = a; bus_wdata = d; bus_be = b; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [4:0] a, input logic [31:0] exp);
        bus_addr = a;
        #1;
        chk(req, bus_rdata, exp);
    endtask

    task automatic keyed(input logic [4:0] a, input logic [31:0] d);
        bus_wr(A_RLD, 32'h80, 4'hF);
        bus_wr(A_RLD, 32'h86, 4'hF);
        bus_wr(a, d, 4'hF);
    endtask

    // Watches n cycles after the current edge; times are relative to it.
    task automatic observe(input int n, output int irq_at, output logic [2:0] irq_val,
                           output int rst_at, output int rst_cnt);
        int base;
        base = cyc; irq_at = -1; irq_val = '0; rst_at = -1; rst_cnt = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (irq_out != 3'b000 && irq_at < 0) begin
                irq_at = cyc - base; irq_val = irq_out;
            end
            if (wdt_rst_out) begin
                rst_cnt++;
                if (rst_at < 0) rst_at = cyc - base;
            end
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int ia, ra, rc;
        logic [2:0] iv;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R13 reset state
        rd_chk("R13", A_CTL, 32'h0);
        rd_chk("R13", A_CFG, 32'h3);
        rd_chk("R13", A_RLD, 32'h0);
        chk("R13", {28'h0, wdt_rst_out, irq_out}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i].wr) bus_wr(VEC[i].addr, VEC[i].data, VEC[i].be);
            else           rd_chk(string'(VEC[i].tag), VEC[i].addr, VEC[i].data);
        end
        rd_chk("R13", A_CFG, 32'h3);

        // Both stages one tick long plus one, fast tick, type 00
        keyed(A_PA, 32'h1);
        keyed(A_PB, 32'h1);
        bus_wr(A_CFG, 32'h04, 4'hF);
        bus_wr(A_CTL, 32'h02, 4'hF);
        keyed(A_RLD, 32'h100);
        observe(11, ia, iv, ra, rc);
        chk("R4", ia, 4);
        chk("R6", {29'h0, iv}, 32'h1);
        chk("R7", ra, 8);
        chk("R7", rc, 1);
        rd_chk("R7", A_RLD, 32'h200);

        // R10 disabled: held, quiet
        bus_wr(A_CTL, 32'h0, 4'hF);
        observe(20, ia, iv, ra, rc);
        chk("R10", ia, -1);
        chk("R10", rc, 0);

        // R8 flag: unkeyed clear ignored, keyed clear works
        bus_wr(A_RLD, 32'h200, 4'hF);
        rd_chk("R8", A_RLD, 32'h200);
        keyed(A_RLD, 32'h200);
        rd_chk("R8", A_RLD, 32'h0);

        // R6 type 10 -> line 2
        bus_wr(A_CFG, 32'h06, 4'hF);
        bus_wr(A_CTL, 32'h02, 4'hF);
        keyed(A_RLD, 32'h100);
        observe(11, ia, iv, ra, rc);
        chk("R6", {29'h0, iv}, 32'h4);
        chk("R6", ia, 4);
        bus_wr(A_CTL, 32'h0, 4'hF);
        keyed(A_RLD, 32'h200);

        // R6 type 11 none, R7 reset suppressed but flag set
        bus_wr(A_CFG, 32'h27, 4'hF);
        bus_wr(A_CTL, 32'h02, 4'hF);
        keyed(A_RLD, 32'h100);
        observe(11, ia, iv, ra, rc);
        chk("R6", ia, -1);
        chk("R7", rc, 0);
        rd_chk("R7", A_RLD, 32'h200);
        bus_wr(A_CTL, 32'h0, 4'hF);
        keyed(A_RLD, 32'h200);

        // R9 timer function
        bus_wr(A_CFG, 32'h04, 4'hF);
        bus_wr(A_CTL, 32'h06, 4'hF);
        keyed(A_RLD, 32'h100);
        observe(11, ia, iv, ra, rc);
        chk("R9", ia, 4);
        chk("R9", rc, 0);
        rd_chk("R9", A_RLD, 32'h0);
        bus_wr(A_CTL, 32'h0, 4'hF);

        // R5 slow tick: 8 clocks per tick
        bus_wr(A_CFG, 32'h00, 4'hF);
        bus_wr(A_CTL, 32'h02, 4'hF);
        keyed(A_RLD, 32'h100);
        observe(20, ia, iv, ra, rc);
        chk("R5", ia, 16);
        bus_wr(A_CTL, 32'h0, 4'hF);
        keyed(A_RLD, 32'h200);

        // R12 reload on the expiry edge wins
        bus_wr(A_CFG, 32'h04, 4'hF);
        bus_wr(A_CTL, 32'h02, 4'hF);
        keyed(A_RLD, 32'h100);
        @(negedge clk);
        keyed(A_RLD, 32'h100);
        chk("R12", {29'h0, irq_out}, 32'h0);
        observe(5, ia, iv, ra, rc);
        chk("R12", ia, 4);

        // R11 lock
        bus_wr(A_CTL, 32'h03, 4'hF);
        bus_wr(A_CTL, 32'h00, 4'hF);
        rd_chk("R11", A_CTL, 32'h3);
        keyed(A_RLD, 32'h100);
        observe(11, ia, iv, ra, rc);
        chk("R11", rc, 1);
        rd_chk("R11", A_CTL, 32'h3);
        rd_chk("R11", A_RLD, 32'h200);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule